// File: doc/BRIEF.md
# Eight-Lane Vector Arithmetic Unit

This unit runs one vector operation over eight 32-bit lanes. Each lane stands for one word of a run of consecutive scratch addresses: lane i lands at address base+i. A caller puts three vector operands, one scalar word, an opcode and a base destination address on the inputs, with `in_valid` high. One clock later the unit presents the eight lane results, the same base address and an error flag, with `out_valid` high. The consumer treats the result as a staged write and commits it at the end of the bundle, so reads in the same bundle still see the old scratch contents.

The unit supports three kinds of operation. A broadcast copies the scalar into every lane. A fused multiply-add computes a*b+c in each lane, with the product and the sum both wrapped to 32 bits. The rest apply one scalar operation in each lane. The lanes are independent: no carry, borrow or error passes from one lane to another.

A two-state controller tracks the output. `ST_IDLE` means no result is pending. `ST_ACTIVE` means a result is being presented. The transitions are:
- IDLE→ACTIVE when an operation is accepted.
- ACTIVE→ACTIVE when a back-to-back operation arrives.
- ACTIVE→IDLE when `in_valid` is low.
- IDLE→IDLE otherwise.

Top module: `vec_lane_unit`

## Requirements
- R1: After reset `out_valid` is 0, `out_vec` is all zeros, `out_err` is 0 and `out_dest` is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. In that cycle `out_dest` equals the `in_dest` that was sampled.
- R3: Opcode 13 (broadcast) puts `in_scalar` in all eight lanes and ignores the three vector operands.
- R4: Opcode 14 (multiply-add) gives ((a*b) mod 2^32 + c) mod 2^32 in each lane.
- R5: Opcodes 0 (add), 1 (subtract) and 2 (multiply) give results modulo 2^32 in each lane. A lane that wraps has no effect on its neighbours.
- R6: Opcodes 3 (floor divide), 4 (ceiling divide) and 10 (remainder) are unsigned. A zero divisor gives a lane result of 0 and marks that lane in error.
- R7: Opcodes 5 (xor), 6 (and) and 7 (or) are bitwise in each lane.
- R8: Opcodes 8 (shift left) and 9 (logical shift right) shift a by b. A shift amount of 32 or more gives 0.
- R9: Opcodes 11 (less-than, unsigned) and 12 (equal) give 1 or 0 in each lane.
- R10: Opcode 15 is illegal. It gives zeros in all lanes and raises `out_err`.
- R11: `out_err` is the OR of the lane errors. It is 0 when no lane errs.
- R12: While `in_valid` is low, `out_vec`, `out_dest` and `out_err` keep their last values, whatever the other inputs do.

Lane i occupies bits [32*i+31 : 32*i] of every vector bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Opcode |
| in_dest | input | 16 | Base destination address |
| in_scalar | input | 32 | Scalar source for broadcast |
| in_a | input | 256 | Vector operand a |
| in_b | input | 256 | Vector operand b |
| in_c | input | 256 | Vector operand c (multiply-add addend) |
| out_valid | output | 1 | Result present |
| out_dest | output | 16 | Base address for the staged write |
| out_vec | output | 256 | Lane results |
| out_err | output | 1 | OR of lane error flags |

## Verification
Two functions can fall in the same cycle. The first case is a zero divisor in one lane while the other lanes divide normally. The output must then carry correct quotients in the healthy lanes, a zero in the faulty lane and a raised `out_err`. The bench provokes this with a directed vector and with random divisors biased towards zero. The second case is a new operation accepted while the previous result is still presented. Back-to-back issues must update every output each cycle without dropping `out_valid`. Each result is compared lane by lane against a reference model in the bench.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_MUL   = 4'd2,
        OP_DIV   = 4'd3,
        OP_CDIV  = 4'd4,
        OP_XOR   = 4'd5,
        OP_AND   = 4'd6,
        OP_OR    = 4'd7,
        OP_SHL   = 4'd8,
        OP_SHR   = 4'd9,
        OP_MOD   = 4'd10,
        OP_LT    = 4'd11,
        OP_EQ    = 4'd12,
        OP_BCAST = 4'd13,
        OP_FMA   = 4'd14,
        OP_BAD   = 4'd15
    } vop_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } vstate_e;
endpackage

// File: rtl/vlu_divider.sv
module vlu_divider #(
    parameter int WORD = 32
) (
    input  logic [WORD-1:0] num,
    input  logic [WORD-1:0] den,
    output logic [WORD-1:0] quot,
    output logic [WORD-1:0] quot_up,
    output logic [WORD-1:0] rem,
    output logic            by_zero
);
    logic [WORD-1:0] safe_den;

    always_comb begin
        by_zero  = (den == '0);
        safe_den = by_zero ? {{(WORD-1){1'b0}}, 1'b1} : den;
        quot     = by_zero ? '0 : num / safe_den;
        rem      = by_zero ? '0 : num % safe_den;
        quot_up  = by_zero ? '0 : quot + {{(WORD-1){1'b0}}, (rem != '0)};
    end
endmodule

// File: rtl/vlu_lane.sv
module vlu_lane
    import vlu_pkg::*;
#(
    parameter int WORD = 32
) (
    input  logic [3:0]      op,
    input  logic [WORD-1:0] a,
    input  logic [WORD-1:0] b,
    input  logic [WORD-1:0] c,
    input  logic [WORD-1:0] s,
    output logic [WORD-1:0] res,
    output logic            err
);
    localparam int SH_W = $clog2(WORD);

    logic [2*WORD-1:0] prod;
    logic [WORD-1:0]   q, qu, r;
    logic              dz;
    logic              big_shift;

    vlu_divider #(.WORD(WORD)) u_div (
        .num     (a),
        .den     (b),
        .quot    (q),
        .quot_up (qu),
        .rem     (r),
        .by_zero (dz)
    );

    always_comb begin
        prod      = a * b;
        big_shift = |b[WORD-1:SH_W];
        res       = '0;
        err       = 1'b0;
        unique case (vop_e'(op))
            OP_ADD:   res = a + b;
            OP_SUB:   res = a - b;
            OP_MUL:   res = prod[WORD-1:0];
            OP_DIV:   begin res = q;  err = dz; end
            OP_CDIV:  begin res = qu; err = dz; end
            OP_MOD:   begin res = r;  err = dz; end
            OP_XOR:   res = a ^ b;
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_SHL:   res = big_shift ? '0 : a << b[SH_W-1:0];
            OP_SHR:   res = big_shift ? '0 : a >> b[SH_W-1:0];
            OP_LT:    res = {{(WORD-1){1'b0}}, (a < b)};
            OP_EQ:    res = {{(WORD-1){1'b0}}, (a == b)};
            OP_BCAST: res = s;
            OP_FMA:   res = prod[WORD-1:0] + c;
            OP_BAD:   err = 1'b1;
        endcase
    end
endmodule

// File: rtl/vec_lane_unit.sv
module vec_lane_unit
    import vlu_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int WORD   = 32,
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [3:0]              in_op,
    input  logic [ADDR_W-1:0]       in_dest,
    input  logic [WORD-1:0]         in_scalar,
    input  logic [LANES*WORD-1:0]   in_a,
    input  logic [LANES*WORD-1:0]   in_b,
    input  logic [LANES*WORD-1:0]   in_c,
    output logic                    out_valid,
    output logic [ADDR_W-1:0]       out_dest,
    output logic [LANES*WORD-1:0]   out_vec,
    output logic                    out_err
);
    localparam int VW = LANES * WORD;

    vstate_e          state_q, state_d;
    logic [VW-1:0]    lane_res;
    logic [LANES-1:0] lane_err;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vlu_lane #(.WORD(WORD)) u_lane (
            .op  (in_op),
            .a   (in_a[i*WORD +: WORD]),
            .b   (in_b[i*WORD +: WORD]),
            .c   (in_c[i*WORD +: WORD]),
            .s   (in_scalar),
            .res (lane_res[i*WORD +: WORD]),
            .err (lane_err[i])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (!in_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec  <= '0;
            out_dest <= '0;
            out_err  <= 1'b0;
        end else if (in_valid) begin
            out_vec  <= lane_res;
            out_dest <= in_dest;
            out_err  <= |lane_err;
        end
    end

    assign out_valid = (state_q == ST_ACTIVE);
endmodule

// File: rtl/vlu_checker.sv
module vlu_checker
    import vlu_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int WORD   = 32,
    parameter int ADDR_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [3:0]            in_op,
    input logic [ADDR_W-1:0]     in_dest,
    input logic [WORD-1:0]       in_scalar,
    input logic                  out_valid,
    input logic [ADDR_W-1:0]     out_dest,
    input logic [LANES*WORD-1:0] out_vec,
    input logic                  out_err
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    p_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> out_dest == $past(in_dest));

    p_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_op == OP_BCAST) |-> (out_vec == {LANES{$past(in_scalar)}} && !out_err));

    p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_op == OP_BAD) |-> (out_err && out_vec == '0));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(out_vec) && $stable(out_dest) && $stable(out_err)));
endmodule

bind vec_lane_unit vlu_checker #(.LANES(LANES), .WORD(WORD), .ADDR_W(ADDR_W)) u_vlu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_dest   (in_dest),
    .in_scalar (in_scalar),
    .out_valid (out_valid),
    .out_dest  (out_dest),
    .out_vec   (out_vec),
    .out_err   (out_err)
);

// File: tb/test_vec_lane_unit.sv
module test_vec_lane_unit;
    localparam int L = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [15:0]  in_dest = '0;
    logic [31:0]  in_scalar = '0;
    logic [255:0] in_a = '0, in_b = '0, in_c = '0;
    logic         out_valid;
    logic [15:0]  out_dest;
    logic [255:0] out_vec;
    logic         out_err;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [255:0] exp_vec = '0;
    logic         exp_err = 1'b0;
    logic [15:0]  exp_dest = '0;

    always #5 clk = ~clk;

    vec_lane_unit i_vec_lane_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dest(in_dest), .in_scalar(in_scalar), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .out_valid(out_valid), .out_dest(out_dest),
        .out_vec(out_vec), .out_err(out_err)
    );

    function automatic logic [31:0] ref_lane(input logic [3:0] op, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] c,
                                             input logic [31:0] s, output logic e);
        logic [63:0] p;
        e = 1'b0;
        p = 64'(a) * 64'(b);
        case (op)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return p[31:0];
            4'd3:  begin if (b == 0) begin e = 1'b1; return 0; end return a / b; end
            4'd4:  begin if (b == 0) begin e = 1'b1; return 0; end
                         return 32'((64'(a) + 64'(b) - 1) / 64'(b)); end
            4'd5:  return a ^ b;
            4'd6:  return a & b;
            4'd7:  return a | b;
            4'd8:  return (b >= 32) ? 32'd0 : a << b;
            4'd9:  return (b >= 32) ? 32'd0 : a >> b;
            4'd10: begin if (b == 0) begin e = 1'b1; return 0; end return a % b; end
            4'd11: return {31'd0, a < b};
            4'd12: return {31'd0, a == b};
            4'd13: return s;
            4'd14: return p[31:0] + c;
            default: begin e = 1'b1; return 0; end
        endcase
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2:    return "R5";
            4'd3, 4'd4, 4'd10:   return "R6";
            4'd5, 4'd6, 4'd7:    return "R7";
            4'd8, 4'd9:          return "R8";
            4'd11, 4'd12:        return "R9";
            4'd13:               return "R3";
            4'd14:               return "R4";
            default:             return "R10";
        endcase
    endfunction

    task automatic issue(input logic [3:0] op, input logic [15:0] d, input logic [31:0] s,
                         input logic [255:0] a, input logic [255:0] b, input logic [255:0] c);
        logic e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dest = d; in_scalar = s;
        in_a = a; in_b = b; in_c = c;
        exp_err = 1'b0;
        for (int i = 0; i < L; i++) begin
            exp_vec[i*32 +: 32] = ref_lane(op, a[i*32 +: 32], b[i*32 +: 32], c[i*32 +: 32], s, e);
            exp_err |= e;
        end
        exp_dest = d;
        @(posedge clk); #1;
        check(req_of(op), out_vec, exp_vec);
        check("R11 err", {255'd0, out_err}, {255'd0, exp_err});
        check("R2 valid/dest", {239'd0, out_valid, out_dest}, {239'd0, 1'b1, exp_dest});
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0; in_op = 4'($urandom); in_dest = 16'($urandom);
        in_scalar = $urandom;
        for (int i = 0; i < L; i++) begin
            in_a[i*32 +: 32] = $urandom; in_b[i*32 +: 32] = 0; in_c[i*32 +: 32] = $urandom;
        end
        @(posedge clk); #1;
        check("R12 hold", {out_vec}, exp_vec);
        check("R12 hold", {238'd0, out_valid, out_err, out_dest}, {238'd0, 1'b0, exp_err, exp_dest});
    endtask

    function automatic logic [31:0] pick_b();
        case ($urandom % 4)
            0: return 0;
            1: return $urandom % 40;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        logic [255:0] a, b, c;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {out_vec}, 256'd0);
        check("R1 reset", {238'd0, out_valid, out_err, out_dest}, 256'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3 broadcast ignores vector operands
        issue(4'd13, 16'h0040, 32'hCAFE_F00D, {8{32'h1111_1111}}, '1, '1);
        // R4 multiply-add with wrapping product and sum
        issue(4'd14, 16'h0048, 0, {8{32'hFFFF_FFFF}}, {8{32'hFFFF_FFFF}}, {8{32'hFFFF_FFFF}});
        // R5 no carry between lanes
        a = '0; b = '0; a[31:0] = 32'hFFFF_FFFF; b[31:0] = 32'd1; b[63:32] = 32'd0;
        issue(4'd0, 16'h0050, 0, a, b, '0);
        // R6 zero divisor in lane 3 only, others valid, same cycle
        for (int i = 0; i < L; i++) begin a[i*32 +: 32] = 100 + i; b[i*32 +: 32] = 7; end
        b[3*32 +: 32] = 0;
        issue(4'd4, 16'h0058, 0, a, b, '0);
        issue(4'd3, 16'h0060, 0, a, b, '0);
        go_idle();
        // R8 shift of 32 or more
        for (int i = 0; i < L; i++) begin a[i*32 +: 32] = 32'h8000_0001; b[i*32 +: 32] = 28 + i; end
        issue(4'd8, 16'h0068, 0, a, b, '0);
        issue(4'd9, 16'h0070, 0, a, b, '0);
        // R10 illegal opcode
        issue(4'd15, 16'h0078, 0, a, b, '0);
        go_idle();
        // R11 error clears on a clean op
        issue(4'd7, 16'h0080, 0, a, b, '0);

        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < L; i++) begin
                a[i*32 +: 32] = ($urandom % 3 == 0) ? b[i*32 +: 32] : $urandom;
                b[i*32 +: 32] = pick_b();
                c[i*32 +: 32] = $urandom;
            end
            issue(4'($urandom), 16'($urandom), $urandom, a, b, c);
            if ($urandom % 4 == 0) go_idle();
        end
        go_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule